// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 14-bit successive-approximation converter. When the conversion-start input rises, the sequencer puts the track/hold into hold and raises a busy flag. It then resolves the result one bit at a time, starting at the most significant bit. For each trial it presents a code to the external DAC and reads back a single comparator bit. When the last bit is settled, it drops busy, releases the hold and loads the finished code into a result register.

Bit trials are paced by one of two conversion clocks. The choice is made at the start edge. If the external-clock pin is low at that moment, a divider on the system clock produces a trial tick every `CLK_DIV` cycles. With 15 ticks (one setup tick and 14 trials) and the default divider at a 200 MHz system clock, a conversion fits within 2.2 µs. If the pin is high at the start edge, the sequencer waits instead for rising edges on that same pin. This allows a gated, noncontinuous clock burst that starts some time after the conversion has begun. All inputs are assumed to be synchronous to the system clock.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, busy_o and hold_o are 0 and trial_o and result_o are 0.
- R2: A rising edge on start_i (low in one sampled cycle, high in the next) while busy_o is 0 sets busy_o and hold_o to 1 on that clock edge, and sets trial_o to 0.
- R3: hold_o equals busy_o on every cycle, and busy_o stays 1 from the start edge until the final trial resolves.
- R4: The first conversion tick sets trial_o to 1 << 13, which is the most significant bit. Each later tick resolves the bit under test: the bit is kept if cmp_i is 1 and cleared if cmp_i is 0. The same tick then sets the next lower bit. Bits below the bit under test are always 0.
- R5: If xclk_i is 0 at the start edge, a tick occurs every CLK_DIV system clocks, so busy_o is high for exactly 15*CLK_DIV cycles.
- R6: If xclk_i is 1 at the start edge, each rising edge of xclk_i (0 in one sampled cycle, 1 in the next) is a tick. busy_o falls on the 15th such edge and stays high for as long as the burst pauses.
- R7: In internal-clock mode, activity on xclk_i has no effect on the conversion. In external-clock mode, the number of elapsed system cycles has no effect on it.
- R8: A start edge while busy_o is 1 is ignored, and a start_i held high does not begin another conversion.
- R9: result_o changes only on the cycle busy_o falls, and takes the resolved code. With an ideal comparator (cmp_i = input >= trial_o), that code equals the input.
- R10: The cycle busy_o falls, hold_o also falls and the track/hold returns to track mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion start; acts on its rising edge |
| xclk_i | input | 1 | Clock-source select at start, then external trial clock |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above trial_o |
| trial_o | output | 14 | Trial code presented to the DAC |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 14 | Last completed conversion result |

## Verification
Several properties are checked on every cycle by assertions: the hold/busy equality, the one-hot bit-under-test pointer, the zero bits below the trial position, the divider bound, the reaction to a start edge, and the rule that the result register moves only when busy falls.

Other behaviour can only be shown by the bench scenarios, which run against a behavioural model compared on every clock. These include:
- the exact conversion length in each clock mode;
- correct codes at zero, full scale and mid-range inputs;
- immunity to start pulses and xclk_i toggles during a conversion;
- a stalled external burst holding busy high.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W       = 14,
  parameter int CLK_DIV = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         xclk_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic         hold_o,
  output logic         busy_o,
  output logic [W-1:0] result_o
);
  localparam int CW = $clog2(CLK_DIV + 1);

  logic          start_q, xclk_q, ext_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  mask_q, trial_q, result_q;
  logic          busy_q, hold_q;

  logic          start_edge, xclk_edge, tick;
  logic [W-1:0]  resolved;

  assign start_edge = start_i & ~start_q;
  assign xclk_edge  = xclk_i & ~xclk_q;
  assign tick       = busy_q & (ext_q ? xclk_edge : (cnt_q == CW'(CLK_DIV - 1)));
  assign resolved   = cmp_i ? trial_q : (trial_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      xclk_q  <= 1'b0;
    end else begin
      start_q <= start_i;
      xclk_q  <= xclk_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!busy_q || tick)     cnt_q <= '0;
    else if (!ext_q)              cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      hold_q   <= 1'b0;
      ext_q    <= 1'b0;
      mask_q   <= '0;
      trial_q  <= '0;
      result_q <= '0;
    end else if (!busy_q) begin
      if (start_edge) begin
        busy_q  <= 1'b1;
        hold_q  <= 1'b1;
        ext_q   <= xclk_i;
        mask_q  <= '0;
        trial_q <= '0;
      end
    end else if (tick) begin
      if (mask_q == '0) begin
        mask_q  <= {1'b1, {(W-1){1'b0}}};
        trial_q <= {1'b1, {(W-1){1'b0}}};
      end else if (mask_q[0]) begin
        trial_q  <= resolved;
        result_q <= resolved;
        mask_q   <= '0;
        busy_q   <= 1'b0;
        hold_q   <= 1'b0;
      end else begin
        trial_q <= resolved | (mask_q >> 1);
        mask_q  <= mask_q >> 1;
      end
    end
  end

  assign trial_o  = trial_q;
  assign hold_o   = hold_q;
  assign busy_o   = busy_q;
  assign result_o = result_q;

  p_hold_tracks_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o == busy_o);

  p_start_begins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !start_q) |=> (busy_o && trial_o == '0));

  p_mask_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_q));

  p_low_bits_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ((trial_o & (mask_q - 1'b1)) == '0));

  p_div_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ext_q) |-> (cnt_q < CW'(CLK_DIV)));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mask_q != '0) |=> (!busy_o || mask_q != '0));

  p_result_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable(result_o));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !hold_o);
endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb_top;
  localparam int W   = 14;
  localparam int DIV = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic xclk_i = 1'b0;
  logic cmp_i;
  logic [W-1:0] trial_o, result_o;
  logic hold_o, busy_o;
  int vin = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign cmp_i = (vin >= int'(trial_o));

  sar_seq #(.W(W), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .xclk_i(xclk_i), .cmp_i(cmp_i),
    .trial_o(trial_o), .hold_o(hold_o), .busy_o(busy_o), .result_o(result_o));

  int m_busy, m_ext, m_cnt, m_steps, m_bit, m_trial, m_res, m_pst, m_px;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ext = 0; m_cnt = 0; m_steps = 0; m_bit = 0;
      m_trial = 0; m_res = 0; m_pst = 0; m_px = 0;
    end else begin
      if (m_busy != 0) begin
        bit t;
        t = 1'b0;
        if (m_ext != 0) t = (xclk_i && m_px == 0);
        else begin
          m_cnt++;
          if (m_cnt == DIV) begin t = 1'b1; m_cnt = 0; end
        end
        if (t) begin
          if (m_steps == 0) begin
            m_bit = W - 1; m_trial = 1 << m_bit;
          end else begin
            if (vin < m_trial) m_trial -= (1 << m_bit);
            if (m_bit == 0) begin m_res = m_trial; m_busy = 0; end
            else begin m_bit--; m_trial += (1 << m_bit); end
          end
          m_steps++;
        end
      end else if (start_i && m_pst == 0) begin
        m_busy = 1; m_ext = xclk_i; m_cnt = 0; m_steps = 0; m_trial = 0;
      end
      m_pst = start_i;
      m_px = xclk_i;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o == m_busy[0], "R3 busy vs model", busy_o, m_busy);
      chk(hold_o == m_busy[0], "R10 hold vs model", hold_o, m_busy);
      chk(int'(trial_o) == m_trial, "R4 trial vs model", trial_o, m_trial);
      chk(int'(result_o) == m_res, "R9 result vs model", result_o, m_res);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic kick(input logic xsel);
    @(negedge clk); start_i = 1'b1; xclk_i = xsel;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xclk_i = 1'b0;
      @(negedge clk); xclk_i = 1'b1;
    end
  endtask

  task automatic int_conv(input int v, input string req);
    int n;
    vin = v;
    kick(1'b0);
    chk(busy_o && hold_o && trial_o == '0, "R2 start response", busy_o, 1);
    n = 1;
    while (busy_o) begin @(negedge clk); n++; if (busy_o) ; end
    n = n - 1;
    chk(n == 15 * DIV, "R5 internal duration", n, 15 * DIV);
    chk(int'(result_o) == v, req, result_o, v);
    chk(!hold_o, "R10 hold released", hold_o, 0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !hold_o && trial_o == '0 && result_o == '0, "R1 in reset", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !hold_o && trial_o == '0 && result_o == '0, "R1 after reset", result_o, 0);

    int_conv(16'h2A5C, "R9 mid code");
    int_conv(0, "R4 zero code");
    int_conv(16'h3FFF, "R4 full scale");
    int_conv(16'h2000, "R4 msb only");

    begin
      int n;
      vin = 16'h0F0F;
      kick(1'b0);
      n = 1;
      while (busy_o) begin
        @(negedge clk);
        xclk_i = ~xclk_i;
        start_i = (n % 7 == 3);
        n++;
      end
      start_i = 1'b0; xclk_i = 1'b0;
      n = n - 1;
      chk(n == 15 * DIV, "R7 R8 internal immune to xclk and start", n, 15 * DIV);
      chk(int'(result_o) == 16'h0F0F, "R7 result", result_o, 16'h0F0F);
    end

    vin = 16'h1234;
    kick(1'b1);
    repeat (50) @(negedge clk);
    chk(busy_o, "R6 waits for burst", busy_o, 1);
    pulses(14);
    @(negedge clk);
    chk(busy_o, "R6 busy before 15th edge", busy_o, 1);
    pulses(1);
    @(negedge clk);
    chk(!busy_o && int'(result_o) == 16'h1234, "R6 ext result", result_o, 16'h1234);

    vin = 16'h3A01;
    xclk_i = 1'b0;
    kick(1'b1);
    pulses(10);
    repeat (600) @(negedge clk);
    chk(busy_o, "R7 ext ignores elapsed cycles", busy_o, 1);
    chk(int'(result_o) == 16'h1234, "R9 result holds mid conversion", result_o, 16'h1234);
    pulses(5);
    @(negedge clk);
    chk(!busy_o && int'(result_o) == 16'h3A01, "R6 stalled burst result", result_o, 16'h3A01);

    vin = 16'h0555;
    xclk_i = 1'b0;
    @(negedge clk); start_i = 1'b1;
    repeat (15 * DIV + 3) @(negedge clk);
    chk(!busy_o && int'(result_o) == 16'h0555, "R9 held-start conversion", result_o, 16'h0555);
    repeat (100) @(negedge clk);
    chk(!busy_o, "R8 level start no retrigger", busy_o, 0);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule